// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block decides when a calendar alarm fires. It holds four alarm fields (day of month, a set of weekdays, hour and minute) and compares them with the running clock values it is given. The comparison happens only in the cycle where the seconds counter carries into the minutes counter. If every field agrees at that moment, a sticky alarm flag is raised. While the interrupt enable is set, the flag also asserts a drive enable that pulls an active-low open-drain request line low. The clock and calendar counters stay outside the block. They supply BCD day, hour and minute values, a one-hot weekday and the carry strobe.

Each field register holds a mask bit in bit 7. When that bit is set, the field matches any current value, so one setting can give hourly, daily or weekday-only alarms. The weekday field holds a set of days, and it matches when the current day belongs to that set. The flag can only be cleared. Software clears it by writing the control register with the flag bit at 0. Writing 1 to the flag bit leaves it unchanged.

Register writes and the clock inputs are plain control signals that the block samples on every clock edge. No transfer here carries a stream of data, so there is no valid/ready pair and no back-pressure: a write presented with `wr_en` high is always taken in that cycle.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` and `irq_drive` are both 0, and every field register and the interrupt enable are 0.
- R2: `alarm_flag` goes from 0 to 1 only at a clock edge where `min_carry` is 1 and all four fields match. It becomes visible in the cycle after that edge.
- R3: Field registers are selected by `wr_sel`: 0 day, 1 weekday, 2 hour, 3 minute, 4 control. In the day, hour and minute registers, bit 7 = 1 makes the field match any value. With bit 7 = 0, bits 6:0 must equal the 7-bit BCD input, so the tens and ones digits must both agree.
- R4: In the weekday register, bits 6:0 are a set of days with bit 0 = Sunday up to bit 6 = Saturday. The field matches when the set includes the one-hot `cur_wday`, or when bit 7 is 1. Several days may be set at once.
- R5: In the control register, bit 0 is the interrupt enable and bit 1 is the flag. A control write with bit 1 = 0 clears the flag. A control write with bit 1 = 1 leaves the flag as it was.
- R6: If a clearing control write and a matching carry arrive at the same edge, the flag ends up 1.
- R7: `irq_drive` is 1 exactly when `alarm_flag` is 1 and the interrupt enable is 1. With the enable at 0, the line is released.
- R8: Once set, the flag stays 1 through later carries that do not match, until a clearing write.
- R9: A register write takes effect at its edge. A carry in the same cycle is compared against the register values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_day | input | 7 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday, one-hot, bit 0 = Sunday |
| cur_hour | input | 7 | Current hour, BCD, 24-hour form |
| cur_min | input | 7 | Current minute, BCD |
| min_carry | input | 1 | One-cycle strobe when the seconds counter carries into the minutes counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 day, 1 weekday, 2 hour, 3 minute, 4 control) |
| wr_data | input | 8 | Write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_drive | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
Both outputs come from registers or from logic on registers. Any carry or write presented before an edge therefore shows its effect on `alarm_flag` and `irq_drive` exactly one edge later. The bench drives its inputs on the falling edge and lets one rising edge pass. It checks on the next falling edge, against a model updated with the register values held before that same edge, which is why same-edge write and carry cases resolve the way R6 and R9 state. Every cycle of both the directed cases and the seeded random run is checked this way.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int VAL_W    = 7;
  localparam int REG_W    = 8;
  localparam int N_FIELDS = 4;
  localparam int SEL_W    = 3;
  localparam int MASK_BIT = REG_W - 1;
  localparam int IE_BIT   = 0;
  localparam int FLAG_BIT = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_DAY  = 3'd0,
    SEL_WDAY = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_MIN  = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [REG_W-1:0]                 wr_data,
  output logic [N_FIELDS-1:0][REG_W-1:0]   fld_q,
  output logic                             ie_q,
  output logic                             clr_req
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fld_q[i] <= '0;
      else if (wr_en && wr_sel == SEL_W'(i))
        fld_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ie_q <= 1'b0;
    else if (wr_en && sel == SEL_CTRL)
      ie_q <= wr_data[IE_BIT];
  end

  // Writing 0 to the flag bit requests a clear; writing 1 requests nothing.
  assign clr_req = wr_en && (sel == SEL_CTRL) && !wr_data[FLAG_BIT];
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import cal_alarm_pkg::*;
(
  input  logic [N_FIELDS-1:0][REG_W-1:0] fld_q,
  input  logic [N_FIELDS-1:0][VAL_W-1:0] cur_vec,
  output logic [N_FIELDS-1:0]            fld_hit,
  output logic                           all_hit
);
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    logic masked;
    assign masked = fld_q[i][MASK_BIT];
    if (i == int'(SEL_WDAY)) begin : g_set
      // set membership: the one-hot current day must land in the selected set
      assign fld_hit[i] = masked || (|(fld_q[i][VAL_W-1:0] & cur_vec[i]));
    end else begin : g_eq
      assign fld_hit[i] = masked || (fld_q[i][VAL_W-1:0] == cur_vec[i]);
    end
  end

  assign all_hit = &fld_hit;
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic min_carry,
  input  logic all_hit,
  input  logic clr_req,
  input  logic ie_q,
  output logic flag_q,
  output logic irq_drive
);
  logic set_evt;
  assign set_evt = min_carry && all_hit;

  // A new event wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_evt)
      flag_q <= 1'b1;
    else if (clr_req)
      flag_q <= 1'b0;
  end

  assign irq_drive = flag_q && ie_q;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] cur_day,
  input  logic [VAL_W-1:0] cur_wday,
  input  logic [VAL_W-1:0] cur_hour,
  input  logic [VAL_W-1:0] cur_min,
  input  logic             min_carry,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             alarm_flag,
  output logic             irq_drive
);
  logic [N_FIELDS-1:0][REG_W-1:0] fld_q;
  logic [N_FIELDS-1:0][VAL_W-1:0] cur_vec;
  logic [N_FIELDS-1:0]            fld_hit;
  logic                           alarm_hit;
  logic                           ie_q;
  logic                           clr_req;

  assign cur_vec[SEL_DAY]  = cur_day;
  assign cur_vec[SEL_WDAY] = cur_wday;
  assign cur_vec[SEL_HOUR] = cur_hour;
  assign cur_vec[SEL_MIN]  = cur_min;

  alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .fld_q   (fld_q),
    .ie_q    (ie_q),
    .clr_req (clr_req)
  );

  alarm_field_cmp u_cmp (
    .fld_q   (fld_q),
    .cur_vec (cur_vec),
    .fld_hit (fld_hit),
    .all_hit (alarm_hit)
  );

  alarm_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .min_carry (min_carry),
    .all_hit   (alarm_hit),
    .clr_req   (clr_req),
    .ie_q      (ie_q),
    .flag_q    (alarm_flag),
    .irq_drive (irq_drive)
  );
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk
  import cal_alarm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             min_carry,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             hit,
  input logic             alarm_flag,
  input logic             irq_drive
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_sel == SEL_W'(SEL_CTRL)) && !wr_data[FLAG_BIT];

  // R2
  flag_needs_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !min_carry) |=> !alarm_flag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_wr) |=> alarm_flag);

  // R6
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry && hit) |=> alarm_flag);

  // R7
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drive |-> alarm_flag);

  // R2
  no_set_without_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !hit) |=> !alarm_flag);
endmodule

bind cal_alarm_match cal_alarm_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .min_carry  (min_carry),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .hit        (alarm_hit),
  .alarm_flag (alarm_flag),
  .irq_drive  (irq_drive)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cur_day = '0, cur_wday = '0, cur_hour = '0, cur_min = '0;
  logic       min_carry = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       alarm_flag, irq_drive;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_fld [4];
  logic       m_ie = 1'b0;
  logic       m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk (clk), .rst_n (rst_n),
    .cur_day (cur_day), .cur_wday (cur_wday), .cur_hour (cur_hour), .cur_min (cur_min),
    .min_carry (min_carry), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .alarm_flag (alarm_flag), .irq_drive (irq_drive)
  );

  function automatic logic exp_match();
    logic d, w, h, m;
    d = m_fld[0][7] || (m_fld[0][6:0] == cur_day);
    w = m_fld[1][7] || ((m_fld[1][6:0] & cur_wday) != 7'd0);
    h = m_fld[2][7] || (m_fld[2][6:0] == cur_hour);
    m = m_fld[3][7] || (m_fld[3][6:0] == cur_min);
    return d && w && h && m;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge; drives, passes one rising edge, checks at the next falling edge.
  task automatic cycle(input string tag, input logic carry, input logic we,
                       input logic [2:0] sel, input logic [7:0] data);
    logic nxt;
    min_carry = carry; wr_en = we; wr_sel = sel; wr_data = data;
    nxt = m_flag;
    if (we && sel == 3'd4 && !data[1]) nxt = 1'b0;
    if (carry && exp_match()) nxt = 1'b1;
    @(posedge clk);
    m_flag = nxt;
    if (we && sel < 3'd4) m_fld[sel] = data;
    if (we && sel == 3'd4) m_ie = data[0];
    @(negedge clk);
    min_carry = 1'b0; wr_en = 1'b0;
    check(tag, alarm_flag, m_flag, "alarm_flag");
    check(tag, irq_drive, m_flag && m_ie, "irq_drive");
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    cycle("R9", 1'b0, 1'b1, sel, data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] pool [4];
    for (int i = 0; i < 4; i++) m_fld[i] = 8'h00;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", alarm_flag, 1'b0, "alarm_flag after reset");
    check("R1", irq_drive, 1'b0, "irq_drive after reset");
    // R1: all-zero registers never match day 0x15 even with a carry
    cur_day = 7'h15; cur_wday = 7'h02; cur_hour = 7'h06; cur_min = 7'h30;
    cycle("R1", 1'b1, 1'b0, 3'd0, 8'h00);

    wr(3'd0, 8'h15); wr(3'd1, 8'h3E); wr(3'd2, 8'h06); wr(3'd3, 8'h30); wr(3'd4, 8'h01);
    cycle("R2", 1'b0, 1'b0, 3'd0, 8'h00);          // match but no carry
    check("R2", alarm_flag, 1'b0, "no carry no flag");
    cycle("R2", 1'b1, 1'b0, 3'd0, 8'h00);          // carry with match
    check("R2", alarm_flag, 1'b1, "flag on carry");
    check("R7", irq_drive, 1'b1, "irq with ie");
    wr(3'd4, 8'h03);                               // flag bit 1 written: no effect
    check("R5", alarm_flag, 1'b1, "write 1 keeps flag");
    cur_min = 7'h31;
    cycle("R8", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R8", alarm_flag, 1'b1, "sticky through mismatch");
    wr(3'd4, 8'h01);
    check("R5", alarm_flag, 1'b0, "clear by write 0");

    cur_min = 7'h30; cur_wday = 7'h01;             // Sunday not in set
    cycle("R4", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R4", alarm_flag, 1'b0, "Sunday excluded");
    cur_wday = 7'h40;                              // Saturday not in set
    cycle("R4", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R4", alarm_flag, 1'b0, "Saturday excluded");
    cur_wday = 7'h08;                              // Wednesday in set
    cycle("R4", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R4", alarm_flag, 1'b1, "Wednesday included");

    cycle("R6", 1'b1, 1'b1, 3'd4, 8'h01);          // clear and match together
    check("R6", alarm_flag, 1'b1, "event beats clear");
    wr(3'd4, 8'h00);
    check("R7", alarm_flag, 1'b0, "cleared, ie off");

    cur_min = 7'h03;                               // digits swapped: no match
    cycle("R3", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R3", alarm_flag, 1'b0, "BCD digits differ");
    cur_min = 7'h30; cur_hour = 7'h11;
    wr(3'd2, 8'hA3);                               // hour masked
    cycle("R3", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R3", alarm_flag, 1'b1, "masked hour matches");
    check("R7", irq_drive, 1'b0, "ie off releases line");
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h80);                               // weekday masked
    cur_wday = 7'h01;
    cycle("R4", 1'b1, 1'b0, 3'd0, 8'h00);
    check("R4", alarm_flag, 1'b1, "masked weekday matches");
    wr(3'd4, 8'h01);
    cycle("R9", 1'b1, 1'b1, 3'd3, 8'h80);          // old minute 0x30 still used
    check("R9", alarm_flag, 1'b1, "old value used at write edge");

    // Random phase
    pool[0] = 7'h01; pool[1] = 7'h15; pool[2] = 7'h23; pool[3] = 7'h59;
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] s;
      logic [7:0] d;
      cur_day  = pool[$urandom_range(3)];
      cur_hour = pool[$urandom_range(3)];
      cur_min  = pool[$urandom_range(3)];
      cur_wday = 7'h01 << $urandom_range(6);
      s = 3'($urandom_range(5));
      d = 8'($urandom);
      if (s != 3'd1 && s < 3'd4) d = {d[7] & d[6], pool[$urandom_range(3)]};
      cycle("R2", ($urandom_range(2) == 0), ($urandom_range(3) == 0), s, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule